// File: doc/BRIEF.md
# Multicart PRG Bank Mapper

This block sits on the cartridge side of an 8-bit console and turns CPU writes in the upper 32 KiB of address space into bank selections for a PRG-ROM of up to 1 MiB. That ROM is organised as eight outer groups, and each group holds eight inner 16 KiB banks. Two configuration registers are loaded from the CPU data bus. Their address decodes overlap: a single write to the lowest 8 KiB of the range loads both registers. A write to the top 8 KiB loads neither.

From the two registers the block takes a 3-bit outer group, a 3-bit inner bank and a 2-bit PRG mode. The outer group bits are scattered across the second register. The PRG address is formed combinationally from the stored configuration and the current CPU address. CPU address bit 14 selects between the lower window (CPU $8000–$BFFF) and the upper window (CPU $C000–$FFFF).

The mode is an enumerated selector with four named states:
- PM_SWITCH_FIXED: a switchable lower window, with the upper window fixed on inner bank 7.
- PM_SWITCH_EVEN: the same layout, but the lower window bank is forced even.
- PM_DUP16: both windows show one 16 KiB bank.
- PM_PAIR32: an even/odd pair of banks forms one 32 KiB block.

The only transitions between modes are register writes that change the mode bits, and a reset, which returns to PM_SWITCH_FIXED. The block also steers the console's nametable RAM A10 line from one of two PPU address bits, which gives vertical or horizontal mirroring.

Top module: `mcart_prg_mapper`

## Requirements
- R1: A write strobe with cpu_addr[15] = 0 changes neither register, so every output stays as it was.
- R2: With cpu_addr[15] = 1, the select register (inner bank in data[2:0], mode-high bit in data[3]) loads when cpu_addr[13] = 0. The group register (outer and mirroring fields) loads when cpu_addr[14] = 0. An $A000–$BFFF write therefore leaves the select register unchanged, and a $C000–$DFFF write leaves the group register unchanged.
- R3: A write to $8000–$9FFF loads the same data byte into both registers on one clock edge. A write to $E000–$FFFF loads neither register.
- R4: The outer group is {group data[0], group data[5], group data[4]} and drives prg_addr[19:17]. prg_addr[13:0] equals cpu_addr[13:0].
- R5: The mode is {select data[3], group data[6]}. In mode 0 (PM_SWITCH_FIXED), a lower-window read (cpu_addr[14] = 0) uses the inner bank, and an upper-window read uses inner bank 7.
- R6: In mode 1 (PM_SWITCH_EVEN), the lower window uses the inner bank with bit 0 cleared, and the upper window uses inner bank 7.
- R7: In mode 2 (PM_DUP16), both windows use the inner bank unchanged.
- R8: In mode 3 (PM_PAIR32), the lower window uses the inner bank with bit 0 cleared, and the upper window uses that even bank plus one.
- R9: Group data[7] = 0 selects vertical mirroring, where ciram_a10 follows ppu_a10. Group data[7] = 1 selects horizontal mirroring, where ciram_a10 follows ppu_a11.
- R10: A synchronous reset clears both registers. Afterwards the mirroring is vertical, the lower window reads bank 0 and the upper window reads bank 7.
- R11: A register write takes effect on the clock edge that samples it, and prg_addr reflects the new configuration within that same clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, sampled on the rising clock edge |
| ppu_a10 | input | 1 | PPU address bit 10 |
| ppu_a11 | input | 1 | PPU address bit 11 |
| prg_addr | output | 20 | PRG-ROM byte address |
| ciram_a10 | output | 1 | Nametable RAM A10 select |

## Verification
The register file is the only sequential element. A write is therefore visible one clock edge after the strobe is presented. prg_addr and ciram_a10 follow the CPU and PPU address inputs with no added latency.

The bench drives inputs on the falling edge and samples a few nanoseconds later, well before the next rising edge. For the write-latency requirement it also samples shortly after the loading edge, while the write address is still applied. Mirroring is probed with both PPU bit patterns inside one cycle, because that path is purely combinational.

// File: rtl/mcart_pkg.sv
package mcart_pkg;

    localparam int DATA_W   = 8;
    localparam int CPU_AW   = 16;
    localparam int INNER_W  = 3;
    localparam int OUTER_W  = 3;
    localparam int WIN_W    = 14;
    localparam int BANK_W   = OUTER_W + INNER_W;
    localparam int PRG_AW   = BANK_W + WIN_W;

    // Bit positions that the decode depends on
    localparam int SEL_DEC_BIT  = 13;  // select register loads when this address bit is 0
    localparam int GRP_DEC_BIT  = 14;  // group register loads when this address bit is 0
    localparam int WIN_BIT      = 14;  // window chooser inside the 32 KiB range
    localparam int MODE_HI_POS  = 3;   // in select data
    localparam int MODE_LO_POS  = 6;   // in group data
    localparam int HORIZ_POS    = 7;   // in group data
    localparam int OUT0_POS     = 4;
    localparam int OUT1_POS     = 5;
    localparam int OUT2_POS     = 0;

    typedef enum logic [1:0] {
        PM_SWITCH_FIXED = 2'd0,
        PM_SWITCH_EVEN  = 2'd1,
        PM_DUP16        = 2'd2,
        PM_PAIR32       = 2'd3
    } prg_mode_e;

    typedef struct packed {
        logic [INNER_W-1:0] inner;
        logic               mode_hi;
    } sel_cfg_t;

    typedef struct packed {
        logic               horiz;
        logic               mode_lo;
        logic [OUTER_W-1:0] outer;
    } grp_cfg_t;

endpackage

// File: rtl/mcart_cfg_regs.sv
module mcart_cfg_regs
    import mcart_pkg::*;
#(
    parameter int AW = CPU_AW,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_data,
    input  logic          cpu_wr,
    output sel_cfg_t      sel_q,
    output grp_cfg_t      grp_q
);

    localparam int TOP_BIT = AW - 1;

    logic     wr_hit;
    logic     ld_sel;
    logic     ld_grp;
    sel_cfg_t sel_d;
    grp_cfg_t grp_d;
    logic     unused_data_bits;

    assign wr_hit = cpu_wr & cpu_addr[TOP_BIT];
    assign ld_sel = wr_hit & ~cpu_addr[SEL_DEC_BIT];
    assign ld_grp = wr_hit & ~cpu_addr[GRP_DEC_BIT];

    always_comb begin
        sel_d.inner   = cpu_data[INNER_W-1:0];
        sel_d.mode_hi = cpu_data[MODE_HI_POS];
        grp_d.horiz   = cpu_data[HORIZ_POS];
        grp_d.mode_lo = cpu_data[MODE_LO_POS];
        grp_d.outer   = {cpu_data[OUT2_POS], cpu_data[OUT1_POS], cpu_data[OUT0_POS]};
    end

    assign unused_data_bits = ^cpu_data[MODE_HI_POS-1:1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else if (ld_sel) begin
            sel_q <= sel_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grp_q <= '0;
        end else if (ld_grp) begin
            grp_q <= grp_d;
        end
    end

endmodule

// File: rtl/mcart_bank_map.sv
module mcart_bank_map
    import mcart_pkg::*;
#(
    parameter int IW = INNER_W,
    parameter int OW = OUTER_W
) (
    input  sel_cfg_t         sel,
    input  grp_cfg_t         grp,
    input  logic             upper_win,
    output logic [OW+IW-1:0] bank
);

    localparam logic [IW-1:0] LAST_INNER = {IW{1'b1}};

    prg_mode_e     mode;
    logic [IW-1:0] inner_even;
    logic [IW-1:0] inner_sel;

    assign mode       = prg_mode_e'({sel.mode_hi, grp.mode_lo});
    assign inner_even = {sel.inner[IW-1:1], 1'b0};

    always_comb begin
        unique case (mode)
            PM_SWITCH_FIXED: inner_sel = upper_win ? LAST_INNER : sel.inner;
            PM_SWITCH_EVEN:  inner_sel = upper_win ? LAST_INNER : inner_even;
            PM_DUP16:        inner_sel = sel.inner;
            PM_PAIR32:       inner_sel = {sel.inner[IW-1:1], upper_win};
            default:         inner_sel = sel.inner;
        endcase
    end

    assign bank = {grp.outer, inner_sel};

endmodule

// File: rtl/mcart_mirror_sel.sv
module mcart_mirror_sel (
    input  logic horiz,
    input  logic ppu_a10,
    input  logic ppu_a11,
    output logic ciram_a10
);

    always_comb begin
        if (horiz) begin
            ciram_a10 = ppu_a11;
        end else begin
            ciram_a10 = ppu_a10;
        end
    end

endmodule

// File: rtl/mcart_prg_mapper.sv
module mcart_prg_mapper
    import mcart_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic              cpu_wr,
    input  logic              ppu_a10,
    input  logic              ppu_a11,
    output logic [PRG_AW-1:0] prg_addr,
    output logic              ciram_a10
);

    sel_cfg_t          sel_q;
    grp_cfg_t          grp_q;
    logic [BANK_W-1:0] bank;

    mcart_cfg_regs #(
        .AW (CPU_AW),
        .DW (DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .cpu_addr (cpu_addr),
        .cpu_data (cpu_data),
        .cpu_wr   (cpu_wr),
        .sel_q    (sel_q),
        .grp_q    (grp_q)
    );

    mcart_bank_map #(
        .IW (INNER_W),
        .OW (OUTER_W)
    ) u_map (
        .sel       (sel_q),
        .grp       (grp_q),
        .upper_win (cpu_addr[WIN_BIT]),
        .bank      (bank)
    );

    mcart_mirror_sel u_mirror (
        .horiz     (grp_q.horiz),
        .ppu_a10   (ppu_a10),
        .ppu_a11   (ppu_a11),
        .ciram_a10 (ciram_a10)
    );

    assign prg_addr = {bank, cpu_addr[WIN_W-1:0]};

endmodule

// File: rtl/mcart_prg_mapper_chk.sv
module mcart_prg_mapper_chk
    import mcart_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [CPU_AW-1:0] cpu_addr,
    input logic [DATA_W-1:0] cpu_data,
    input logic              cpu_wr,
    input logic [PRG_AW-1:0] prg_addr,
    input sel_cfg_t          sel_q,
    input grp_cfg_t          grp_q
);

    localparam int OFS_INNER = WIN_W;

    AST_LOW_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && !cpu_addr[CPU_AW-1]) |=> ($stable(sel_q) && $stable(grp_q))); // R1

    AST_A000_KEEPS_SELECT: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr[15:13] == 3'b101) |=> $stable(sel_q)); // R2

    AST_C000_KEEPS_GROUP: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr[15:13] == 3'b110) |=> $stable(grp_q)); // R2

    AST_LOAD_BOTH: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr[15:13] == 3'b100) |=>
        (sel_q.inner == $past(cpu_data[2:0]) && grp_q.horiz == $past(cpu_data[7]))); // R3

    AST_TOP_WRITE_NONE: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr[15:13] == 3'b111) |=> ($stable(sel_q) && $stable(grp_q))); // R3

    AST_FIXED_UPPER_BANK: assert property (@(posedge clk) disable iff (rst)
        (!sel_q.mode_hi && cpu_addr[WIN_BIT]) |-> (prg_addr[OFS_INNER +: INNER_W] == 3'd7)); // R5

    AST_DUP_WINDOWS: assert property (@(posedge clk) disable iff (rst)
        (sel_q.mode_hi && !grp_q.mode_lo) |-> (prg_addr[OFS_INNER +: INNER_W] == sel_q.inner)); // R7

    AST_PAIR_PARITY: assert property (@(posedge clk) disable iff (rst)
        (sel_q.mode_hi && grp_q.mode_lo) |-> (prg_addr[OFS_INNER] == cpu_addr[WIN_BIT])); // R8

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (sel_q == '0 && grp_q == '0)); // R10

endmodule

bind mcart_prg_mapper mcart_prg_mapper_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cpu_addr (cpu_addr),
    .cpu_data (cpu_data),
    .cpu_wr   (cpu_wr),
    .prg_addr (prg_addr),
    .sel_q    (sel_q),
    .grp_q    (grp_q)
);

// File: tb/mcart_prg_mapper_tb.sv
module mcart_prg_mapper_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cpu_addr;
    logic [7:0]  cpu_data;
    logic        cpu_wr;
    logic        ppu_a10;
    logic        ppu_a11;
    logic [19:0] prg_addr;
    logic        ciram_a10;

    int          checks = 0;
    int          errors = 0;
    logic [7:0]  m_sel = 8'h00;
    logic [7:0]  m_grp = 8'h00;

    always #10 clk = ~clk;  // 50 MHz

    mcart_prg_mapper u_dut (
        .clk       (clk),
        .rst       (rst),
        .cpu_addr  (cpu_addr),
        .cpu_data  (cpu_data),
        .cpu_wr    (cpu_wr),
        .ppu_a10   (ppu_a10),
        .ppu_a11   (ppu_a11),
        .prg_addr  (prg_addr),
        .ciram_a10 (ciram_a10)
    );

    function automatic logic [5:0] exp_bank(input logic [7:0] s, input logic [7:0] g,
                                            input logic upper);
        logic [2:0] outer;
        logic [2:0] inner;
        logic [1:0] mode;
        outer = {g[0], g[5], g[4]};
        inner = s[2:0];
        mode  = {s[3], g[6]};
        case (mode)
            2'd0:    return {outer, upper ? 3'd7 : inner};
            2'd1:    return {outer, upper ? 3'd7 : {inner[2:1], 1'b0}};
            2'd2:    return {outer, inner};
            default: return {outer, inner[2:1], upper};
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic write_cpu(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a;
        cpu_data = d;
        cpu_wr   = 1'b1;
        @(posedge clk);
        if (a[15]) begin
            if (!a[13]) m_sel = d;
            if (!a[14]) m_grp = d;
        end
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic probe(input string req);
        for (int up = 0; up < 2; up++) begin
            logic [13:0] ofs;
            @(negedge clk);
            ofs = 14'($urandom);
            cpu_addr = {1'b1, up[0], ofs};
            #5;
            check(req, up ? "upper window" : "lower window", {12'd0, prg_addr},
                  {12'd0, exp_bank(m_sel, m_grp, up[0]), ofs});
        end
        ppu_a10 = 1'b1;
        ppu_a11 = 1'b0;
        #2;
        check(req, "ciram a10/11=10", {31'd0, ciram_a10}, {31'd0, ~m_grp[7]});
        ppu_a10 = 1'b0;
        ppu_a11 = 1'b1;
        #2;
        check(req, "ciram a10/11=01", {31'd0, ciram_a10}, {31'd0, m_grp[7]});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1DEA5EED));
        rst = 1'b1; cpu_addr = 16'h0; cpu_data = 8'h0; cpu_wr = 1'b0;
        ppu_a10 = 1'b0; ppu_a11 = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        probe("R10");                                            // reset state

        write_cpu(16'h8000, 8'h80); probe("R3");                 // both loaded
        write_cpu(16'h8000, 8'h05); write_cpu(16'hA000, 8'h80); probe("R2");
        write_cpu(16'hC000, 8'h01); probe("R2");
        write_cpu(16'h9FFF, 8'h03); write_cpu(16'hE000, 8'hFF); probe("R3");
        write_cpu(16'hFFFF, 8'h5A); probe("R3");
        write_cpu(16'h7FFF, 8'hFF); write_cpu(16'h0000, 8'h4A); probe("R1");

        write_cpu(16'h8000, 8'h00);
        write_cpu(16'hA000, 8'h10); probe("R4");                 // outer 1
        write_cpu(16'hA000, 8'h01); probe("R4");                 // outer 4 from data bit 0
        write_cpu(16'hB000, 8'h31); probe("R4");                 // outer 7

        write_cpu(16'hA000, 8'h00); write_cpu(16'hC000, 8'h03); probe("R5");
        write_cpu(16'hA000, 8'h40); write_cpu(16'hC000, 8'h03); probe("R6");
        write_cpu(16'hA000, 8'h00); write_cpu(16'hC000, 8'h08); probe("R7");
        write_cpu(16'hC000, 8'h0D); probe("R7");
        write_cpu(16'hA000, 8'h40); write_cpu(16'hC000, 8'h0A); probe("R8");
        write_cpu(16'hC000, 8'h0B); probe("R8");
        write_cpu(16'hA000, 8'h80); probe("R9");
        write_cpu(16'hA000, 8'h00); probe("R9");

        // R11: new configuration visible inside the loading clock period
        @(negedge clk);
        cpu_addr = 16'h8123; cpu_data = 8'h16; cpu_wr = 1'b1;
        @(posedge clk);
        m_sel = 8'h16; m_grp = 8'h16;
        #5;
        check("R11", "same-period update", {12'd0, prg_addr},
              {12'd0, exp_bank(m_sel, m_grp, 1'b0), 14'h0123});
        @(negedge clk);
        cpu_wr = 1'b0;

        // R10 again: reset in mid-run
        write_cpu(16'h8000, 8'hFF);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        m_sel = 8'h00; m_grp = 8'h00;
        probe("R10");

        for (int i = 0; i < 400; i++) begin
            logic [15:0] a;
            logic [7:0]  d;
            a = 16'($urandom);
            d = 8'($urandom);
            write_cpu(a, d);
            probe("R2");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule